// File: doc/BRIEF.md
# Shift-Aware Keyboard Code Encoder

This block turns a bank of 40 active-low key lines into a 6-bit character code on a parallel bus. Thirty-eight of the lines are printable keys: the letters a to z, the digits 0 to 9, '+' and '='. The last two lines are a left and a right shift key. Holding either shift key turns a letter key into its uppercase code. Digits and the two symbols give the same code with or without shift. This lets 38 physical keys cover a 64-character code space.

Each input line already passes through an analog RC filter upstream, so the block does no digital debounce. It does bring every line into its clock domain through a two-flop synchroniser. It then picks one key when several are held at once and maps that key, together with the shift state, to a code.

The code, a valid flag and an active-low status LED are all registered outputs.

Top module: `kbd_code_encoder`

## Requirements
- R1: While reset is high, and on the first clock after it, `code` is 0, `code_valid` is 0 and `led_n` is 1.
- R2: A key line that reads high is idle. When every line is high, `code_valid` is 0.
- R3: Line positions on `key_n` are fixed. Lines 0 to 25 are the letters a to z. With no shift held, line i gives code i.
- R4: Lines 38 and 39 are the two shift keys. While either one is low, letter line i gives code 26+i, which is uppercase A to Z.
- R5: Lines 26 to 35 are the digits 0 to 9 and give codes 52 to 61. Line 36 ('+') gives 62 and line 37 ('=') gives 63. These codes are the same whether or not shift is held.
- R6: When more than one printable line is low, the line with the lowest index sets the code.
- R7: A shift line that is low while no printable line is low gives `code_valid` = 0 and `code` = 0.
- R8: `led_n` is 0 exactly when `code_valid` is 1.
- R9: A change on `key_n` reaches the outputs on the third rising clock edge after it: two synchroniser stages and one output register. The outputs still hold the old result after the second edge.
- R10: `code` is 0 whenever `code_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_n | input | 40 | Key lines, active low: 0-25 letters, 26-35 digits, 36 '+', 37 '=', 38-39 shift |
| code | output | 6 | Registered character code |
| code_valid | output | 1 | High while a printable key is held |
| led_n | output | 1 | Status LED drive, low while `code_valid` is high |

## Verification
The bench builds the block with its default parameters: 26 letter lines, 12 other printable lines and two synchroniser stages. These values make the whole 64-entry code space reachable. Every letter is driven both with and without shift, using each shift key on its own. Every digit and symbol is driven under both shift states. Overlapping key presses test the lowest-index rule, including the case where a letter competes with a symbol while shift is held. The bench also samples between the second and third clock edges to confirm the three-edge delay.

// File: rtl/kbd_enc_pkg.sv
package kbd_enc_pkg;
  // Default sizes of the key bank
  localparam int DEF_ALPHA = 26;  // letter keys, case-switched by shift
  localparam int DEF_OTHER = 12;  // digits and symbols, shift-independent
  localparam int DEF_SYNC  = 2;   // synchroniser depth
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int WIDTH  = 40,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // Stage registers; reset to all ones, the idle level of an active-low line
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '1;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/kbd_prio_pick.sv
module kbd_prio_pick #(
  parameter int N     = 38,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top down so that the lowest set bit is written last
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/kbd_code_map.sv
module kbd_code_map #(
  parameter int N_ALPHA = 26,
  parameter int IDX_W   = 6,
  parameter int CODE_W  = 6
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              shift,
  output logic [CODE_W-1:0] code
);
  localparam int UPPER_OFS = N_ALPHA;

  logic is_alpha;
  assign is_alpha = (int'(idx) < N_ALPHA);

  // Letters: lower block, or upper block when shifted.
  // Other keys: placed after both letter blocks, shift ignored.
  always_comb begin
    if (is_alpha && !shift) code = CODE_W'(idx);
    else                    code = CODE_W'(idx) + CODE_W'(UPPER_OFS);
  end
endmodule

// File: rtl/kbd_code_encoder.sv
module kbd_code_encoder
  import kbd_enc_pkg::*;
#(
  parameter int N_ALPHA     = DEF_ALPHA,
  parameter int N_OTHER     = DEF_OTHER,
  parameter int SYNC_STAGES = DEF_SYNC,
  localparam int N_PRINT    = N_ALPHA + N_OTHER,
  localparam int N_LINES    = N_PRINT + 2,
  localparam int CODE_W     = $clog2(2 * N_ALPHA + N_OTHER),
  localparam int IDX_W      = $clog2(N_PRINT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] key_n,
  output logic [CODE_W-1:0]  code,
  output logic               code_valid,
  output logic               led_n
);
  logic [N_LINES-1:0] key_s_n;
  logic [N_PRINT-1:0] pressed;
  logic               shift_s;
  logic               hit;
  logic [IDX_W-1:0]   idx;
  logic [CODE_W-1:0]  code_nx;

  kbd_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (key_n),
    .dout(key_s_n)
  );

  assign pressed = ~key_s_n[N_PRINT-1:0];
  assign shift_s = ~key_s_n[N_PRINT] | ~key_s_n[N_PRINT+1];

  kbd_prio_pick #(.N(N_PRINT), .IDX_W(IDX_W)) u_pick (
    .req(pressed),
    .hit(hit),
    .idx(idx)
  );

  kbd_code_map #(.N_ALPHA(N_ALPHA), .IDX_W(IDX_W), .CODE_W(CODE_W)) u_map (
    .idx  (idx),
    .shift(shift_s),
    .code (code_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code       <= '0;
      code_valid <= 1'b0;
      led_n      <= 1'b1;
    end else begin
      code       <= hit ? code_nx : '0;
      code_valid <= hit;
      led_n      <= ~hit;
    end
  end

  // R7: shift alone (no printable key synchronised) never yields a valid code
  p_shift_alone_r7: assert property (@(posedge clk) disable iff (rst)
    (pressed == '0) |=> (!code_valid && code == '0));

  // R8: LED drive is the inverse of the valid flag
  p_led_follows_valid_r8: assert property (@(posedge clk) disable iff (rst)
    led_n == !code_valid);

  // R10: no stray code while idle
  p_idle_code_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !code_valid |-> code == '0);

  // R3/R6: lowest letter line held without shift wins with its own index
  p_first_letter_r3: assert property (@(posedge clk) disable iff (rst)
    (pressed[0] && !shift_s) |=> (code_valid && code == '0));

  // R4/R6: same line with shift gives the first uppercase code
  p_first_letter_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (pressed[0] && shift_s) |=> (code_valid && code == CODE_W'(N_ALPHA)));
endmodule

// File: tb/tb_kbd_code_encoder.sv
module tb_kbd_code_encoder;
  localparam int NL = 40;

  logic          clk = 1'b0;
  logic          rst;
  logic [NL-1:0] key_n;
  logic [5:0]    code;
  logic          code_valid;
  logic          led_n;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [5:0] code;
    logic       valid;
    string      req;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  kbd_code_encoder dut (
    .clk       (clk),
    .rst       (rst),
    .key_n     (key_n),
    .code      (code),
    .code_valid(code_valid),
    .led_n     (led_n)
  );

  task automatic check(input string req, input logic [5:0] c, input logic v);
    checks++;
    if (code !== c || code_valid !== v || led_n !== ~v) begin
      errors++;
      $display("FAIL %s: code=%0d valid=%0b led_n=%0b expected code=%0d valid=%0b led_n=%0b",
               req, code, code_valid, led_n, c, v, ~v);
    end
  endtask

  // Reference model built from the requirement text
  function automatic exp_t model(input logic [NL-1:0] k, input string req);
    exp_t e;
    logic sh;
    e.code  = '0;
    e.valid = 1'b0;
    e.req   = req;
    sh = !k[38] || !k[39];
    for (int i = 37; i >= 0; i--) begin
      if (!k[i]) begin
        e.valid = 1'b1;
        if (i < 26)      e.code = sh ? 6'(26 + i) : 6'(i);
        else if (i < 36) e.code = 6'(52 + (i - 26));
        else if (i == 36) e.code = 6'd62;
        else              e.code = 6'd63;
      end
    end
    return e;
  endfunction

  // Driver: apply a key pattern, wait past the pipeline, hand expectation to the monitor
  task automatic drive(input logic [NL-1:0] k, input string req);
    @(negedge clk);
    key_n = k;
    repeat (3) @(posedge clk);
    sb.push_back(model(k, req));
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compare outputs against the queued expectation
  initial begin
    forever begin
      exp_t e;
      wait (sb.size() != 0);
      @(negedge clk);
      e = sb.pop_front();
      check(e.req, e.code, e.valid);
    end
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  function automatic logic [NL-1:0] one(input int i);
    logic [NL-1:0] k = '1;
    k[i] = 1'b0;
    return k;
  endfunction

  initial begin
    logic [NL-1:0] k;
    rst   = 1'b1;
    key_n = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 6'd0, 1'b0);
    key_n = one(5);  // pressed during reset must not show
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 6'd0, 1'b0);
    key_n = '1;
    repeat (4) @(negedge clk);

    drive('1, "R2 idle");

    // R3 and R4: every letter, unshifted, left shift, right shift
    for (int i = 0; i < 26; i++) begin
      drive(one(i), "R3 letter");
      k = one(i); k[38] = 1'b0;
      drive(k, "R4 letter left shift");
      k = one(i); k[39] = 1'b0;
      drive(k, "R4 letter right shift");
    end

    // R5: digits and symbols under both shift states
    for (int i = 26; i < 38; i++) begin
      drive(one(i), "R5 other key");
      k = one(i); k[38] = 1'b0; k[39] = 1'b0;
      drive(k, "R5 other key shifted");
    end

    // R6: overlapping keys
    k = one(10); k[3] = 1'b0; k[30] = 1'b0;
    drive(k, "R6 lowest wins");
    k = one(37); k[36] = 1'b0;
    drive(k, "R6 symbols");
    k = one(25); k[37] = 1'b0; k[39] = 1'b0;
    drive(k, "R6 letter vs symbol shifted");
    k = one(26); k[0] = 1'b0;
    drive(k, "R6 a vs digit 0");
    drive('0, "R6 all low");

    // R7: shift alone
    drive(one(38), "R7 left shift alone");
    drive(one(39), "R7 right shift alone");
    k = one(38); k[39] = 1'b0;
    drive(k, "R7 both shifts");

    // R9: three-edge latency, measured directly
    @(negedge clk);
    key_n = one(36);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R9 after two edges", 6'd0, 1'b0);
    @(negedge clk);
    check("R9 after three edges", 6'd62, 1'b1);
    key_n = '1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R9 release two edges", 6'd62, 1'b1);
    @(negedge clk);
    check("R10 release three edges", 6'd0, 1'b0);

    // R1: reset while a key is held
    key_n = one(7);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", 6'd0, 1'b0);
    rst = 1'b0;

    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    report();
  end
endmodule